// File: doc/BRIEF.md
# Software-Managed Unified Translation Buffer

This block is a fully associative address-translation buffer. One lookup port serves both instruction and data fetches. Software alone fills it: each write names the slot to fill. The hardware never picks a victim, so software can keep critical mappings resident by never overwriting their slots. Every slot has its own page size, from 1 KB to 16 MB in steps of four. Every slot also carries an owner tag, which is compared against a process-identifier register held inside the block.

A lookup presents a virtual address and gets its result one cycle later. The result has a hit or miss flag, the index of the slot that translated it, the real address, and a flag that marks multiple matches. On a miss, software walks its own page table and writes a new slot. The process identifier lives in a 32-bit privileged register, reached through a small register-access port at address 0x3B1.

Top module: `utlb_top`

## Requirements
- R1: After reset every slot is invalid, so any lookup misses, and the process-identifier register reads 0.
- R2: There are 64 slots. A write changes only the slot named by `wr_idx_i`, and all other slots keep translating as before.
- R3: The size code s (0..7) gives a page of 2^(10+2s) bytes: 0=1 KB, 1=4 KB, 2=16 KB, 3=64 KB, 4=256 KB, 5=1 MB, 6=4 MB, 7=16 MB. Only virtual-address bits [31:10+2s] are compared with the stored page number, which covers virtual bits [31:10].
- R4: On a hit, real address bits [31:10+2s] come from the stored real page number, and bits [9+2s:0] come straight from the virtual address.
- R5: A slot whose owner tag is 0 matches under any process identifier. A nonzero tag must equal the 8-bit process identifier for the slot to match.
- R6: A slot matches only while its valid bit is set. Writing a slot with `wr_valid_i`=0 invalidates it.
- R7: The result appears in the cycle after `lk_req_i`, with `lk_done_o`=1. In cycles that follow no request, done, hit, miss and multi are all 0.
- R8: In a result cycle, exactly one of hit and miss is 1. Miss is raised when no valid slot matches.
- R9: When several slots match, the lowest-numbered one supplies the index and the real address, and `lk_multi_o` is 1.
- R10: The process-identifier register sits at address 0x3B1 and holds 8 bits. A read returns it in bits [7:0], and bits [31:8] read as 0. Writes to bits [31:8] are ignored. An access to any other address changes nothing and raises no error.
- R11: An access to 0x3B1 with `spr_priv_i`=0 is refused. `spr_err_o` pulses in the next cycle, the register keeps its value, and `spr_rdata_o` is left unchanged.
- R12: A lookup in the same cycle as a slot write or a register write sees the slot contents and the process identifier as they were before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_req_i | input | 1 | Lookup request |
| lk_va_i | input | 32 | Virtual address to translate |
| lk_done_o | output | 1 | Lookup result valid this cycle |
| lk_hit_o | output | 1 | A slot translated the address |
| lk_miss_o | output | 1 | No slot matched |
| lk_multi_o | output | 1 | More than one slot matched |
| lk_idx_o | output | 6 | Index of the winning slot |
| lk_ra_o | output | 32 | Translated real address |
| wr_en_i | input | 1 | Slot write strobe |
| wr_idx_i | input | 6 | Slot to write |
| wr_valid_i | input | 1 | Valid bit to store |
| wr_epn_i | input | 22 | Virtual page number (virtual bits 31:10) |
| wr_size_i | input | 3 | Page size code |
| wr_tid_i | input | 8 | Owner tag, 0 = shared by all processes |
| wr_rpn_i | input | 22 | Real page number (real bits 31:10) |
| spr_valid_i | input | 1 | Register access strobe |
| spr_we_i | input | 1 | 1 = write, 0 = read |
| spr_priv_i | input | 1 | Access made in privileged state |
| spr_addr_i | input | 10 | Register address |
| spr_wdata_i | input | 32 | Write data |
| spr_rdata_o | output | 32 | Read data, updated the cycle after a granted read |
| spr_err_o | output | 1 | Non-privileged access refused |

## Verification
Multiple matches are the hardest case to reach from the ports. Random page numbers almost never overlap, so the bench builds them on purpose. It places a small page inside a large one that has a higher index, gives the same page to two slots, and flips owner tags so that a match drops in and out. It then walks the winner across invalidation and rewrite. Same-cycle write and lookup collisions are driven directly. The random phase draws most lookup addresses from inside stored pages, so that hits dominate and the pass-through of the in-page address bits is covered for every page size.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int unsigned MIN_PG_SHIFT = 10;  // smallest page is 1 KB
  localparam int unsigned SIZE_W       = 3;

  typedef enum logic [SIZE_W-1:0] {
    PG_1K   = 3'd0,
    PG_4K   = 3'd1,
    PG_16K  = 3'd2,
    PG_64K  = 3'd3,
    PG_256K = 3'd4,
    PG_1M   = 3'd5,
    PG_4M   = 3'd6,
    PG_16M  = 3'd7
  } pg_size_e;
endpackage

// File: rtl/utlb_pid_reg.sv
module utlb_pid_reg #(
  parameter int unsigned REG_W    = 32,
  parameter int unsigned PID_W    = 8,
  parameter int unsigned ADDR_W   = 10,
  parameter logic [ADDR_W-1:0] PID_ADDR = 10'h3B1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              spr_valid_i,
  input  logic              spr_we_i,
  input  logic              spr_priv_i,
  input  logic [ADDR_W-1:0] spr_addr_i,
  input  logic [REG_W-1:0]  spr_wdata_i,
  output logic [REG_W-1:0]  spr_rdata_o,
  output logic              spr_err_o,
  output logic [PID_W-1:0]  pid_o
);
  logic sel, grant;
  logic unused_rsvd;

  assign sel         = spr_valid_i && (spr_addr_i == PID_ADDR);
  assign grant       = sel && spr_priv_i;
  assign unused_rsvd = ^spr_wdata_i[REG_W-1:PID_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pid_o       <= '0;
      spr_rdata_o <= '0;
      spr_err_o   <= 1'b0;
    end else begin
      spr_err_o <= sel && !spr_priv_i;
      if (grant && spr_we_i)  pid_o <= spr_wdata_i[PID_W-1:0];
      if (grant && !spr_we_i) spr_rdata_o <= {{(REG_W-PID_W){1'b0}}, pid_o};
    end
  end
endmodule

// File: rtl/utlb_entry_array.sv
module utlb_entry_array
  import utlb_pkg::*;
#(
  parameter int unsigned N     = 64,
  parameter int unsigned PN_W  = 22,
  parameter int unsigned PID_W = 8,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic                      wr_valid_i,
  input  logic [PN_W-1:0]           wr_epn_i,
  input  logic [SIZE_W-1:0]         wr_size_i,
  input  logic [PID_W-1:0]          wr_tid_i,
  input  logic [PN_W-1:0]           wr_rpn_i,
  input  logic [PN_W-1:0]           lk_vpn_i,
  input  logic [PID_W-1:0]          pid_i,
  output logic [N-1:0]              match_o,
  output logic [N-1:0][PN_W-1:0]    ra_pn_o
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    logic              valid_q;
    logic [PN_W-1:0]   epn_q, rpn_q, keep_m;
    logic [SIZE_W-1:0] size_q;
    logic [PID_W-1:0]  tid_q;
    logic              wsel;

    assign wsel = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   valid_q <= 1'b0;
      else if (wsel) valid_q <= wr_valid_i;
    end

    always_ff @(posedge clk_i) begin
      if (wsel) begin
        epn_q  <= wr_epn_i;
        rpn_q  <= wr_rpn_i;
        size_q <= wr_size_i;
        tid_q  <= wr_tid_i;
      end
    end

    // each size step removes two compared bits
    assign keep_m     = {PN_W{1'b1}} << {size_q, 1'b0};
    assign match_o[g] = valid_q && (((lk_vpn_i ^ epn_q) & keep_m) == '0)
                        && ((tid_q == '0) || (tid_q == pid_i));
    assign ra_pn_o[g] = (rpn_q & keep_m) | (lk_vpn_i & ~keep_m);
  end
endmodule

// File: rtl/utlb_prio_sel.sv
module utlb_prio_sel #(
  parameter int unsigned N = 64,
  localparam int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     match_i,
  output logic             any_o,
  output logic             multi_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o   = |match_i;
  assign multi_o = |(match_i & (match_i - N'(1)));

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/utlb_top.sv
module utlb_top
  import utlb_pkg::*;
#(
  parameter int unsigned N      = 64,
  parameter int unsigned VA_W   = 32,
  parameter int unsigned PID_W  = 8,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned ADDR_W = 10,
  parameter logic [ADDR_W-1:0] PID_ADDR = 10'h3B1,
  localparam int unsigned IDX_W = $clog2(N),
  localparam int unsigned PN_W  = VA_W - MIN_PG_SHIFT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_req_i,
  input  logic [VA_W-1:0]   lk_va_i,
  output logic              lk_done_o,
  output logic              lk_hit_o,
  output logic              lk_miss_o,
  output logic              lk_multi_o,
  output logic [IDX_W-1:0]  lk_idx_o,
  output logic [VA_W-1:0]   lk_ra_o,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_valid_i,
  input  logic [PN_W-1:0]   wr_epn_i,
  input  logic [SIZE_W-1:0] wr_size_i,
  input  logic [PID_W-1:0]  wr_tid_i,
  input  logic [PN_W-1:0]   wr_rpn_i,
  input  logic              spr_valid_i,
  input  logic              spr_we_i,
  input  logic              spr_priv_i,
  input  logic [ADDR_W-1:0] spr_addr_i,
  input  logic [REG_W-1:0]  spr_wdata_i,
  output logic [REG_W-1:0]  spr_rdata_o,
  output logic              spr_err_o
);
  logic [PID_W-1:0]           pid;
  logic [N-1:0]               match;
  logic [N-1:0][PN_W-1:0]     ra_pn_all;
  logic                       any_hit, multi_hit;
  logic [IDX_W-1:0]           win_idx;

  utlb_pid_reg #(
    .REG_W(REG_W), .PID_W(PID_W), .ADDR_W(ADDR_W), .PID_ADDR(PID_ADDR)
  ) pid_i (
    .clk_i, .rst_ni,
    .spr_valid_i, .spr_we_i, .spr_priv_i, .spr_addr_i, .spr_wdata_i,
    .spr_rdata_o, .spr_err_o,
    .pid_o (pid)
  );

  utlb_entry_array #(.N(N), .PN_W(PN_W), .PID_W(PID_W)) array_i (
    .clk_i, .rst_ni,
    .wr_en_i, .wr_idx_i, .wr_valid_i, .wr_epn_i, .wr_size_i, .wr_tid_i, .wr_rpn_i,
    .lk_vpn_i (lk_va_i[VA_W-1:MIN_PG_SHIFT]),
    .pid_i    (pid),
    .match_o  (match),
    .ra_pn_o  (ra_pn_all)
  );

  utlb_prio_sel #(.N(N)) prio_i (
    .match_i (match),
    .any_o   (any_hit),
    .multi_o (multi_hit),
    .idx_o   (win_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o  <= 1'b0;
      lk_hit_o   <= 1'b0;
      lk_miss_o  <= 1'b0;
      lk_multi_o <= 1'b0;
      lk_idx_o   <= '0;
      lk_ra_o    <= '0;
    end else begin
      lk_done_o  <= lk_req_i;
      lk_hit_o   <= lk_req_i && any_hit;
      lk_miss_o  <= lk_req_i && !any_hit;
      lk_multi_o <= lk_req_i && multi_hit;
      if (lk_req_i) begin
        lk_idx_o <= win_idx;
        lk_ra_o  <= {ra_pn_all[win_idx], lk_va_i[MIN_PG_SHIFT-1:0]};
      end
    end
  end
endmodule

// File: rtl/utlb_checker.sv
module utlb_checker #(
  parameter int unsigned VA_W   = 32,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned PID_W  = 8,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned OFF_W  = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             lk_req_i,
  input logic [VA_W-1:0]  lk_va_i,
  input logic             lk_done_o,
  input logic             lk_hit_o,
  input logic             lk_miss_o,
  input logic             lk_multi_o,
  input logic [IDX_W-1:0] lk_idx_o,
  input logic [VA_W-1:0]  lk_ra_o,
  input logic             spr_priv_i,
  input logic             spr_valid_i,
  input logic [REG_W-1:0] spr_rdata_o,
  input logic             spr_err_o
);
  p_done_follows_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> lk_done_o);
  p_idle_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lk_req_i |=> !lk_done_o && !lk_hit_o && !lk_miss_o && !lk_multi_o);
  p_hit_xor_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_done_o |-> $onehot({lk_hit_o, lk_miss_o}));
  p_multi_is_hit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_multi_o |-> lk_hit_o);
  p_offset_passes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_req_i |=> (lk_hit_o -> lk_ra_o[OFF_W-1:0] == $past(lk_va_i[OFF_W-1:0])));
  p_rsvd_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_rdata_o[REG_W-1:PID_W] == '0);
  p_err_needs_user_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spr_valid_i && spr_priv_i) |=> !spr_err_o);
  p_err_keeps_rdata_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spr_err_o |-> $stable(spr_rdata_o));

  logic unused_idx;
  assign unused_idx = ^lk_idx_o;
endmodule

bind utlb_top utlb_checker #(
  .VA_W(VA_W), .REG_W(REG_W), .PID_W(PID_W), .IDX_W(IDX_W), .OFF_W(10)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_req_i(lk_req_i), .lk_va_i(lk_va_i),
  .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_miss_o(lk_miss_o),
  .lk_multi_o(lk_multi_o), .lk_idx_o(lk_idx_o), .lk_ra_o(lk_ra_o),
  .spr_priv_i(spr_priv_i), .spr_valid_i(spr_valid_i),
  .spr_rdata_o(spr_rdata_o), .spr_err_o(spr_err_o)
);

// File: tb/utlb_tb_top.sv
`timescale 1ns/1ps
module utlb_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_req = 1'b0;
  logic [31:0] lk_va = '0;
  logic        lk_done, lk_hit, lk_miss, lk_multi;
  logic [5:0]  lk_idx;
  logic [31:0] lk_ra;
  logic        wr_en = 1'b0, wr_valid = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [21:0] wr_epn = '0, wr_rpn = '0;
  logic [2:0]  wr_size = '0;
  logic [7:0]  wr_tid = '0;
  logic        spr_valid = 1'b0, spr_we = 1'b0, spr_priv = 1'b0;
  logic [9:0]  spr_addr = '0;
  logic [31:0] spr_wdata = '0, spr_rdata;
  logic        spr_err;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  utlb_top dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_req_i(lk_req), .lk_va_i(lk_va), .lk_done_o(lk_done), .lk_hit_o(lk_hit),
    .lk_miss_o(lk_miss), .lk_multi_o(lk_multi), .lk_idx_o(lk_idx), .lk_ra_o(lk_ra),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_valid_i(wr_valid), .wr_epn_i(wr_epn),
    .wr_size_i(wr_size), .wr_tid_i(wr_tid), .wr_rpn_i(wr_rpn),
    .spr_valid_i(spr_valid), .spr_we_i(spr_we), .spr_priv_i(spr_priv),
    .spr_addr_i(spr_addr), .spr_wdata_i(spr_wdata), .spr_rdata_o(spr_rdata),
    .spr_err_o(spr_err)
  );

  // reference model
  logic        m_valid [64];
  logic [21:0] m_epn [64], m_rpn [64];
  logic [2:0]  m_size [64];
  logic [7:0]  m_tid [64];
  logic [7:0]  m_pid;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [21:0] keep_mask(input logic [2:0] s);
    return 22'h3FFFFF << (2 * s);
  endfunction

  task automatic ref_lookup(input logic [31:0] va, output bit hit, output bit multi,
                            output logic [5:0] idx, output logic [31:0] ra);
    int cnt = 0;
    hit = 0; multi = 0; idx = '0; ra = '0;
    for (int i = 0; i < 64; i++) begin
      logic [21:0] k;
      k = keep_mask(m_size[i]);
      if (m_valid[i] && (((va[31:10] ^ m_epn[i]) & k) == 0)
          && (m_tid[i] == 0 || m_tid[i] == m_pid)) begin
        if (cnt == 0) begin
          idx = 6'(i);
          ra  = {(m_rpn[i] & k) | (va[31:10] & ~k), va[9:0]};
        end
        cnt++;
      end
    end
    hit = (cnt > 0);
    multi = (cnt > 1);
  endtask

  task automatic write_slot(input logic [5:0] i, input bit v, input logic [21:0] e,
                            input logic [2:0] s, input logic [7:0] t, input logic [21:0] r);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_valid = v; wr_epn = e; wr_size = s; wr_tid = t; wr_rpn = r;
    @(negedge clk);
    wr_en = 0;
    m_valid[i] = v; m_epn[i] = e; m_size[i] = s; m_tid[i] = t; m_rpn[i] = r;
  endtask

  task automatic lookup_chk(input logic [31:0] va, input string req);
    bit h, m; logic [5:0] ei; logic [31:0] er;
    ref_lookup(va, h, m, ei, er);
    @(negedge clk);
    lk_req = 1; lk_va = va;
    @(negedge clk);
    lk_req = 0;
    chk(lk_done === 1'b1, {req, " done"}, 64'(lk_done), 64'd1);
    chk(lk_hit === h && lk_miss === !h, {req, " hit/miss"}, {62'd0, lk_hit, lk_miss}, {62'd0, h, !h});
    chk(lk_multi === m, {req, " multi"}, 64'(lk_multi), 64'(m));
    if (h) begin
      chk(lk_idx === ei, {req, " idx"}, 64'(lk_idx), 64'(ei));
      chk(lk_ra === er, {req, " ra"}, 64'(lk_ra), 64'(er));
    end
  endtask

  task automatic spr_op(input bit we, input bit priv, input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic err);
    @(negedge clk);
    spr_valid = 1; spr_we = we; spr_priv = priv; spr_addr = a; spr_wdata = d;
    @(negedge clk);
    spr_valid = 0; spr_we = 0;
    rd = spr_rdata; err = spr_err;
    if (we && priv && a == 10'h3B1) m_pid = d[7:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] rd; logic err;
    void'($urandom(32'd20240517));
    for (int i = 0; i < 64; i++) begin
      m_valid[i] = 0; m_epn[i] = '0; m_rpn[i] = '0; m_size[i] = '0; m_tid[i] = '0;
    end
    m_pid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    spr_op(0, 1, 10'h3B1, 0, rd, err);
    chk(rd === 32'h0, "R1 pid after reset", 64'(rd), 64'd0);
    lookup_chk(32'h1234_5678, "R1");
    chk(lk_miss === 1'b1, "R1 miss after reset", 64'(lk_miss), 64'd1);
    @(negedge clk);
    chk(!lk_done && !lk_hit && !lk_miss, "R7 idle flags", {61'd0, lk_done, lk_hit, lk_miss}, 64'd0);

    // R10 register access
    spr_op(1, 1, 10'h3B1, 32'h1234_56AB, rd, err);
    spr_op(0, 1, 10'h3B1, 0, rd, err);
    chk(rd === 32'h0000_00AB, "R10 reserved bits", 64'(rd), 64'hAB);
    spr_op(1, 1, 10'h3B0, 32'h0000_0011, rd, err);
    chk(err === 1'b0, "R10 other addr no error", 64'(err), 64'd0);
    spr_op(0, 1, 10'h3B1, 0, rd, err);
    chk(rd === 32'hAB, "R10 other addr ignored", 64'(rd), 64'hAB);

    // R11 non-privileged refused
    spr_op(1, 0, 10'h3B1, 32'h55, rd, err);
    chk(err === 1'b1, "R11 write refused", 64'(err), 64'd1);
    spr_op(0, 0, 10'h3B1, 0, rd, err);
    chk(err === 1'b1 && rd === 32'hAB, "R11 read refused", {31'd0, err, rd}, {31'd0, 1'b1, 32'hAB});
    spr_op(0, 1, 10'h3B1, 0, rd, err);
    chk(rd === 32'hAB, "R11 pid kept", 64'(rd), 64'hAB);

    // R3 smallest page: neighbour page misses
    write_slot(6'd3, 1, 22'h0ABCDE, 3'd0, 8'h00, 22'h111111);
    lookup_chk({22'h0ABCDE, 10'h3FF}, "R3 1K hit");
    lookup_chk({22'h0ABCDF, 10'h000}, "R3 1K neighbour");
    chk(lk_miss === 1'b1, "R3 1K neighbour miss", 64'(lk_miss), 64'd1);

    // R4 largest page with stray low bits in stored numbers
    write_slot(6'd10, 1, 22'h2A5FFF, 3'd7, 8'h00, 22'h13C123);
    lookup_chk(32'hA9_12_34_56, "R4 16M");
    chk(lk_ra === 32'h4F12_3456, "R4 16M ra", 64'(lk_ra), 64'h4F12_3456);

    // R5 owner tag
    write_slot(6'd20, 1, 22'h001000, 3'd2, 8'h77, 22'h002000);
    lookup_chk({22'h001003, 10'h123}, "R5 tag mismatch");
    chk(lk_miss === 1'b1, "R5 tag mismatch miss", 64'(lk_miss), 64'd1);
    spr_op(1, 1, 10'h3B1, 32'h77, rd, err);
    lookup_chk({22'h001003, 10'h123}, "R5 tag match");
    chk(lk_hit === 1'b1, "R5 tag match hit", 64'(lk_hit), 64'd1);

    // R9 multiple matches: small page in low slot inside big page
    write_slot(6'd40, 1, 22'h100000, 3'd6, 8'h00, 22'h200000);
    write_slot(6'd12, 1, 22'h100040, 3'd1, 8'h00, 22'h300000);
    lookup_chk({22'h100041, 10'h2A}, "R9 lowest wins");
    chk(lk_idx === 6'd12 && lk_multi === 1'b1, "R9 idx12 multi", {57'd0, lk_multi, lk_idx}, {57'd0, 1'b1, 6'd12});
    // R6 invalidate low slot
    write_slot(6'd12, 0, 22'h100040, 3'd1, 8'h00, 22'h300000);
    lookup_chk({22'h100041, 10'h2A}, "R6 invalidated");
    chk(lk_idx === 6'd40 && lk_multi === 1'b0, "R6 falls to idx40", {57'd0, lk_multi, lk_idx}, {57'd0, 1'b0, 6'd40});

    // R12 same-cycle write and lookup see old state
    begin
      bit h, m; logic [5:0] ei; logic [31:0] er;
      ref_lookup({22'h0ABCDE, 10'h010}, h, m, ei, er);
      @(negedge clk);
      lk_req = 1; lk_va = {22'h0ABCDE, 10'h010};
      wr_en = 1; wr_idx = 6'd3; wr_valid = 0; wr_epn = 22'h0ABCDE; wr_size = 0; wr_tid = 0; wr_rpn = 0;
      @(negedge clk);
      lk_req = 0; wr_en = 0; m_valid[3] = 0;
      chk(lk_hit === 1'b1 && lk_ra === er, "R12 old slot seen", {31'd0, lk_hit, lk_ra}, {31'd0, 1'b1, er});
      lookup_chk({22'h0ABCDE, 10'h010}, "R12 after write");
      chk(lk_miss === 1'b1, "R12 after write miss", 64'(lk_miss), 64'd1);
      @(negedge clk);
      lk_req = 1; lk_va = {22'h001003, 10'h0};
      spr_valid = 1; spr_we = 1; spr_priv = 1; spr_addr = 10'h3B1; spr_wdata = 32'h01;
      @(negedge clk);
      lk_req = 0; spr_valid = 0; spr_we = 0; m_pid = 8'h01;
      chk(lk_hit === 1'b1 && lk_idx === 6'd20, "R12 old pid seen", {57'd0, lk_hit, lk_idx}, {57'd0, 1'b1, 6'd20});
    end

    // R2 locking: random overwrites of other slots leave slot 10 intact
    for (int it = 0; it < 400; it++) begin
      logic [5:0] i;
      logic [7:0] t;
      logic [2:0] s;
      int pick;
      i = 6'($urandom_range(0, 63));
      if (i == 6'd10) i = 6'd11;
      s = 3'($urandom_range(0, 5));
      case ($urandom_range(0, 2))
        0: t = 8'h00;
        1: t = m_pid;
        default: t = 8'($urandom);
      endcase
      write_slot(i, ($urandom_range(0, 7) != 0), 22'($urandom) & 22'h0FFFFF, s, t, 22'($urandom));
      if (it % 16 == 0) spr_op(1, 1, 10'h3B1, $urandom, rd, err);
      pick = $urandom_range(0, 63);
      if ($urandom_range(0, 3) != 0)
        lookup_chk({m_epn[pick] ^ (22'($urandom) & ~keep_mask(m_size[pick])), 10'($urandom)}, "R4 random");
      else
        lookup_chk($urandom, "R8 random");
    end
    lookup_chk(32'hA9FF_0001, "R2 locked slot");
    chk(lk_idx === 6'd10 && lk_ra === 32'h4FFF_0001, "R2 locked slot kept",
        {26'd0, lk_idx, lk_ra}, {26'd0, 6'd10, 32'h4FFF_0001});

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule